// File: doc/BRIEF.md
# SDRAM Command-Mode Init Sequencer

This block lets a host bring an SDRAM device up, and keep it refreshed, one command at a time. The host writes a single command word. The word carries a 3-bit mode code, a select bit for each of the two chip selects, a repeat count for auto-refresh bursts, and a value for the device mode register. The engine turns the word into the matching pattern on the SDRAM command pins, applies it only to the selected chip selects, and holds a busy status bit until the command has finished. A write that arrives while busy is high is dropped, and a sticky error bit records that it happened.

Software runs power-up in this order: start clock, wait at least 200 µs (the host times this), precharge all, an auto-refresh burst, load mode register, and finally normal mode. Once normal mode is entered, a refresh timer counts down from a programmable value. Each time it expires, the engine issues one auto-refresh to the chip selects named by the normal-mode command. A refresh that falls due while a host command is running is held until that command ends. Self-refresh and power-down drop CKE and stop the periodic refresh.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, CKE is low, both chip selects are high (deselected), and status busy (bit 5) and error (bit 0) are 0.
- R2: Mode code 1 (clock start) raises CKE and drives one NOP cycle (RAS_n=1, CAS_n=1, WE_n=1) on the selected chip selects.
- R3: Mode code 2 (precharge all) drives RAS_n=0, CAS_n=1, WE_n=0 with address bit 10 high for one cycle.
- R4: Mode code 4 (load mode register) drives RAS_n=0, CAS_n=0, WE_n=0 for one cycle, with command-word bits [21:9] on the address lines. Within that field, burst length is in bits [2:0] and CAS latency in bits [6:4].
- R5: Command-word bit 4 selects chip select 0 (sd_cs_n[0]) and bit 3 selects chip select 1 (sd_cs_n[1]). A command with neither bit set asserts no chip select.
- R6: Mode code 3 (auto-refresh) issues (bits [8:5] + 1) refresh commands (RAS_n=0, CAS_n=0, WE_n=1), spaced TRC_CYC cycles apart. Busy stays high for (count × TRC_CYC) cycles.
- R7: Busy, in status bit 5, rises in the cycle a command is accepted. For every mode other than auto-refresh it stays high for exactly one cycle.
- R8: A command word written while busy is high has no effect on the pins. It sets status bit 0, which stays set until reset.
- R9: The refresh period field is rate_word[14:1], and its reset value is 8196. Once in normal mode (code 0), the first auto-refresh appears (period + 2) cycles after the command, and later ones come every (period + 1) cycles. Each goes to the chip selects named by the normal-mode command.
- R10: A periodic refresh that falls due while busy is high is held. It is issued in the cycle after busy falls.
- R11: Self-refresh (code 5) drives the refresh pattern with CKE low. Power-down (code 6) drives a NOP with CKE low. Both stop periodic refresh. Normal mode raises CKE again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 22 | Mode [2:0], chip select 1 [3], chip select 0 [4], repeat-minus-one [8:5], mode-register value [21:9] |
| rate_wr | input | 1 | Refresh period write strobe |
| rate_word | input | 14 | Refresh period field, indexed [14:1] |
| status | output | 8 | Bit 5 busy, bit 0 sticky error, other bits 0 |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address, held at 0 |
| sd_addr | output | 13 | Address lines |

## Verification
The bench writes a command on the clock edge between two falling edges. The command's pin pattern, CKE change and busy rise are all visible at the very next falling edge. Busy falls one cycle later for single commands, and (count × TRC_CYC) cycles later for refresh bursts. The bench samples at exactly those falling edges and counts falling edges to check burst spacing. It also counts falling edges to confirm the first periodic refresh at (period + 2) cycles after normal mode, the later spacing of (period + 1), and that a held refresh appears one cycle after busy drops. Dropped writes and stopped refresh are checked by watching the pins over a whole window.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // command word field layout
    localparam int MODE_LSB    = 0;
    localparam int MODE_W      = 3;
    localparam int CS1_BIT     = 3;
    localparam int CS0_BIT     = 4;
    localparam int RPT_LSB     = 5;
    localparam int RPT_W       = 4;
    localparam int PAYLOAD_LSB = 9;

    // status layout
    localparam int STAT_W    = 8;
    localparam int STAT_BUSY = 5;
    localparam int STAT_ERR  = 0;

    localparam int NUM_CS  = 2;
    localparam int A10_BIT = 10;

    typedef enum logic [2:0] {
        MD_NORMAL     = 3'd0,
        MD_CLK_ON     = 3'd1,
        MD_PRECHARGE  = 3'd2,
        MD_AUTO_REF   = 3'd3,
        MD_LOAD_MODE  = 3'd4,
        MD_SELF_REF   = 3'd5,
        MD_POWER_DOWN = 3'd6,
        MD_RESERVED   = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        OP_DESEL,
        OP_NOP,
        OP_PRE_ALL,
        OP_REFRESH,
        OP_LOAD_MODE
    } op_e;

    typedef struct packed {
        mode_e              mode;
        logic [NUM_CS-1:0]  sel;
        logic [RPT_W-1:0]   rpt_m1;
    } host_cmd_t;

    typedef struct packed {
        logic select;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
        logic use_payload;
    } pin_code_t;

    function automatic pin_code_t op_to_pins(op_e op);
        pin_code_t p;
        p = '{select: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
              a10: 1'b0, use_payload: 1'b0};
        unique case (op)
            OP_NOP:       p.select = 1'b1;
            OP_PRE_ALL:   begin p.select = 1'b1; p.ras_n = 1'b0; p.we_n = 1'b0; p.a10 = 1'b1; end
            OP_REFRESH:   begin p.select = 1'b1; p.ras_n = 1'b0; p.cas_n = 1'b0; end
            OP_LOAD_MODE: begin p.select = 1'b1; p.ras_n = 1'b0; p.cas_n = 1'b0;
                                p.we_n = 1'b0; p.use_payload = 1'b1; end
            default:      p.select = 1'b0;
        endcase
        return p;
    endfunction

    function automatic logic mode_stops_refresh(mode_e m);
        return (m == MD_CLK_ON) || (m == MD_SELF_REF) || (m == MD_POWER_DOWN);
    endfunction

endpackage

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
    parameter int RATE_W       = 14,
    parameter int DEFAULT_RATE = 8196
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_val,
    input  logic              enable,
    output logic              req
);

    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_W'(DEFAULT_RATE);
        end else if (rate_wr) begin
            rate_q <= rate_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RATE_W'(DEFAULT_RATE);
            req   <= 1'b0;
        end else if (!enable) begin
            cnt_q <= rate_q;
            req   <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= rate_q;
            req   <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            req   <= 1'b0;
        end
    end

    // R9
    refresh_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (req && rate_q != '0) |=> !req);

endmodule

// File: rtl/seq_cmd_engine.sv
module seq_cmd_engine
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int TRC_CYC = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_wr,
    input  logic [PAYLOAD_LSB+ADDR_W-1:0] cmd_word,
    input  logic                          refresh_req,
    output logic                          busy,
    output logic                          err,
    output logic                          refresh_on,
    output logic                          cke,
    output op_e                           op,
    output logic [NUM_CS-1:0]             sel,
    output logic [ADDR_W-1:0]             payload
);

    localparam int GAP_W = (TRC_CYC > 2) ? $clog2(TRC_CYC) : 1;
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(TRC_CYC - 1);

    typedef enum logic [1:0] { ST_IDLE, ST_SINGLE, ST_BURST } st_e;

    st_e               state_q;
    host_cmd_t         dec;
    logic              accept;
    logic              ref_go;
    logic              pend_q;
    logic [NUM_CS-1:0] ref_sel_q;
    logic [RPT_W-1:0]  left_q;
    logic [GAP_W-1:0]  gap_q;

    always_comb begin
        dec.mode   = mode_e'(cmd_word[MODE_LSB +: MODE_W]);
        dec.sel    = {cmd_word[CS1_BIT], cmd_word[CS0_BIT]};
        dec.rpt_m1 = cmd_word[RPT_LSB +: RPT_W];
    end

    assign accept = cmd_wr && !busy;
    assign ref_go = (refresh_req || pend_q) && refresh_on && !busy && !cmd_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            busy       <= 1'b0;
            err        <= 1'b0;
            refresh_on <= 1'b0;
            cke        <= 1'b0;
            op         <= OP_DESEL;
            sel        <= '0;
            payload    <= '0;
            pend_q     <= 1'b0;
            ref_sel_q  <= '0;
            left_q     <= '0;
            gap_q      <= '0;
        end else begin
            op <= OP_DESEL;
            if (cmd_wr && busy) begin
                err <= 1'b1;
            end
            if (ref_go) begin
                pend_q <= 1'b0;
            end else if (refresh_req) begin
                pend_q <= 1'b1;
            end

            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        busy    <= 1'b1;
                        sel     <= dec.sel;
                        payload <= cmd_word[PAYLOAD_LSB +: ADDR_W];
                        state_q <= ST_SINGLE;
                        if (mode_stops_refresh(dec.mode)) begin
                            refresh_on <= 1'b0;
                            pend_q     <= 1'b0;
                        end
                        unique case (dec.mode)
                            MD_NORMAL: begin
                                cke        <= 1'b1;
                                refresh_on <= 1'b1;
                                ref_sel_q  <= dec.sel;
                            end
                            MD_CLK_ON: begin
                                cke <= 1'b1;
                                op  <= OP_NOP;
                            end
                            MD_PRECHARGE:  op <= OP_PRE_ALL;
                            MD_AUTO_REF: begin
                                op      <= OP_REFRESH;
                                left_q  <= dec.rpt_m1;
                                gap_q   <= GAP_RELOAD;
                                state_q <= ST_BURST;
                            end
                            MD_LOAD_MODE:  op <= OP_LOAD_MODE;
                            MD_SELF_REF: begin
                                cke <= 1'b0;
                                op  <= OP_REFRESH;
                            end
                            MD_POWER_DOWN: begin
                                cke <= 1'b0;
                                op  <= OP_NOP;
                            end
                            default:       op <= OP_DESEL;
                        endcase
                    end else if (ref_go) begin
                        busy    <= 1'b1;
                        sel     <= ref_sel_q;
                        op      <= OP_REFRESH;
                        left_q  <= '0;
                        gap_q   <= GAP_RELOAD;
                        state_q <= ST_BURST;
                    end
                end
                ST_SINGLE: begin
                    busy    <= 1'b0;
                    state_q <= ST_IDLE;
                end
                ST_BURST: begin
                    if (gap_q != '0) begin
                        gap_q <= gap_q - 1'b1;
                    end else if (left_q != '0) begin
                        op     <= OP_REFRESH;
                        left_q <= left_q - 1'b1;
                        gap_q  <= GAP_RELOAD;
                    end else begin
                        busy    <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7
    single_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SINGLE) |=> (!busy && state_q == ST_IDLE));

    // R8
    ignored_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> err);

    // R8
    ignored_keeps_target_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> $stable(sel));

    // R6
    burst_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_REFRESH && state_q == ST_BURST) |=> (op != OP_REFRESH));

    // R10
    deferred_req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (refresh_req && busy) |=> pend_q);

    // R11
    self_ref_stops_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_REFRESH && !cke) |-> !refresh_on);

endmodule

// File: rtl/seq_pin_driver.sv
module seq_pin_driver
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  op_e               op,
    input  logic [NUM_CS-1:0] sel,
    input  logic [ADDR_W-1:0] payload,
    input  logic              cke_in,
    output logic              sd_cke,
    output logic [NUM_CS-1:0] sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);

    pin_code_t code;

    assign code     = op_to_pins(op);
    assign sd_cke   = cke_in;
    assign sd_ras_n = code.ras_n;
    assign sd_cas_n = code.cas_n;
    assign sd_we_n  = code.we_n;
    assign sd_ba    = '0;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign sd_cs_n[i] = !(code.select && sel[i]);
    end

    always_comb begin
        if (code.use_payload) begin
            sd_addr = payload;
        end else begin
            sd_addr = '0;
            sd_addr[A10_BIT] = code.a10;
        end
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int BA_W         = 2,
    parameter int RATE_W       = 14,
    parameter int DEFAULT_RATE = 8196,
    parameter int TRC_CYC      = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_wr,
    input  logic [PAYLOAD_LSB+ADDR_W-1:0] cmd_word,
    input  logic                          rate_wr,
    input  logic [RATE_W:1]               rate_word,
    output logic [STAT_W-1:0]             status,
    output logic                          sd_cke,
    output logic [NUM_CS-1:0]             sd_cs_n,
    output logic                          sd_ras_n,
    output logic                          sd_cas_n,
    output logic                          sd_we_n,
    output logic [BA_W-1:0]               sd_ba,
    output logic [ADDR_W-1:0]             sd_addr
);

    logic              busy;
    logic              err;
    logic              refresh_on;
    logic              refresh_req;
    logic              cke;
    op_e               op;
    logic [NUM_CS-1:0] sel;
    logic [ADDR_W-1:0] payload;

    seq_refresh_timer #(
        .RATE_W       (RATE_W),
        .DEFAULT_RATE (DEFAULT_RATE)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .rate_wr  (rate_wr),
        .rate_val (rate_word),
        .enable   (refresh_on),
        .req      (refresh_req)
    );

    seq_cmd_engine #(
        .ADDR_W  (ADDR_W),
        .TRC_CYC (TRC_CYC)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr),
        .cmd_word    (cmd_word),
        .refresh_req (refresh_req),
        .busy        (busy),
        .err         (err),
        .refresh_on  (refresh_on),
        .cke         (cke),
        .op          (op),
        .sel         (sel),
        .payload     (payload)
    );

    seq_pin_driver #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_pins (
        .op       (op),
        .sel      (sel),
        .payload  (payload),
        .cke_in   (cke),
        .sd_cke   (sd_cke),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_addr  (sd_addr)
    );

    always_comb begin
        status            = '0;
        status[STAT_BUSY] = busy;
        status[STAT_ERR]  = err;
    end

    // R3
    pre_all_a10_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_cs_n != '1 && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[A10_BIT]);

    // R5
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        !status[STAT_BUSY] |-> (sd_cs_n == '1));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sd_cke && sd_cs_n == '1 && status == '0));

endmodule

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/1ps
module sdram_cmd_seq_test;

    localparam int ADDR_W = 13;
    localparam int TRC    = 4;
    localparam int DEF_RT = 8196;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [21:0] cmd_word = '0;
    logic        rate_wr = 1'b0;
    logic [14:1] rate_word = '0;
    logic [7:0]  status;
    logic        sd_cke;
    logic [1:0]  sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [ADDR_W-1:0] sd_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_seq uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .rate_wr(rate_wr), .rate_word(rate_word), .status(status),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    function automatic bit is_aref();
        return (sd_cs_n != 2'b11) && !sd_ras_n && !sd_cas_n && sd_we_n;
    endfunction

    function automatic bit is_pre();
        return (sd_cs_n != 2'b11) && !sd_ras_n && sd_cas_n && !sd_we_n;
    endfunction

    function automatic int pins3();
        return {29'd0, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // waits for idle, writes one command; returns at the falling edge after acceptance
    task automatic send(input int mode, input bit cs0, input bit cs1, input int rpt, input int pl);
        int guard = 0;
        while (status[5] && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        cmd_word        = '0;
        cmd_word[2:0]   = 3'(mode);
        cmd_word[3]     = cs1;
        cmd_word[4]     = cs0;
        cmd_word[8:5]   = 4'(rpt);
        cmd_word[21:9]  = 13'(pl);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "cke", sd_cke, 0);
        chk("R1", "cs_n", sd_cs_n, 3);
        chk("R1", "status", status, 0);
    endtask

    task automatic t_clock_start();
        send(1, 1'b1, 1'b0, 0, 0);
        chk("R2", "cke after start", sd_cke, 1);
        chk("R5", "cs_n cs0 only", sd_cs_n, 2'b10);
        chk("R2", "nop pattern", pins3(), 3'b111);
        chk("R7", "busy in command cycle", status[5], 1);
        @(negedge clk);
        chk("R7", "busy after one cycle", status[5], 0);
        chk("R5", "deselect after", sd_cs_n, 2'b11);
    endtask

    task automatic t_no_target();
        send(2, 1'b0, 1'b0, 0, 0);
        chk("R5", "no chip select with no bits", sd_cs_n, 2'b11);
        chk("R7", "busy still pulses", status[5], 1);
        @(negedge clk);
    endtask

    task automatic t_precharge();
        send(2, 1'b1, 1'b1, 0, 0);
        chk("R3", "precharge pattern", pins3(), 3'b010);
        chk("R3", "a10 high", sd_addr[10], 1);
        chk("R5", "both selects", sd_cs_n, 2'b00);
        @(negedge clk);
    endtask

    task automatic t_refresh_burst();
        int nb = 0, na = 0, prev = -1, bad_gap = 0, bad_cs = 0;
        send(3, 1'b1, 1'b0, 7, 0);
        while (status[5] && nb < 300) begin
            if (is_aref()) begin
                if (prev >= 0 && (nb - prev) != TRC) bad_gap++;
                if (sd_cs_n != 2'b10) bad_cs++;
                prev = nb;
                na++;
            end
            nb++;
            @(negedge clk);
        end
        chk("R6", "refresh count", na, 8);
        chk("R6", "busy cycles", nb, 8 * TRC);
        chk("R6", "spacing errors", bad_gap, 0);
        chk("R5", "burst target errors", bad_cs, 0);
    endtask

    task automatic t_ignored_write();
        int na = 0, np = 0;
        send(3, 1'b1, 1'b1, 1, 0);
        for (int i = 0; i < 14; i++) begin
            if (is_aref()) na++;
            if (is_pre()) np++;
            if (i == 1) begin
                cmd_word      = '0;
                cmd_word[2:0] = 3'd2;
                cmd_word[3]   = 1'b1;
                cmd_word[4]   = 1'b1;
                cmd_wr        = 1'b1;
            end else begin
                cmd_wr = 1'b0;
            end
            @(negedge clk);
        end
        chk("R8", "precharge from dropped write", np, 0);
        chk("R6", "two refreshes", na, 2);
        chk("R8", "sticky error", status[0], 1);
    endtask

    task automatic t_load_mode();
        send(4, 1'b0, 1'b1, 0, 13'h033);
        chk("R4", "load pattern", pins3(), 3'b000);
        chk("R4", "mode value on address", sd_addr, 13'h033);
        chk("R5", "cs1 only", sd_cs_n, 2'b01);
        @(negedge clk);
    endtask

    task automatic t_normal_default();
        int n = 0;
        send(0, 1'b1, 1'b1, 0, 0);
        chk("R11", "cke in normal", sd_cke, 1);
        while (!is_aref() && n < 9000) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "first refresh at default period", n, DEF_RT + 2);
    endtask

    task automatic t_power_down();
        int na = 0;
        send(6, 1'b1, 1'b1, 0, 0);
        chk("R11", "cke low in power-down", sd_cke, 0);
        chk("R11", "power-down nop", pins3(), 3'b111);
        rate_word = 14'd20;
        rate_wr   = 1'b1;
        @(negedge clk);
        rate_wr   = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (is_aref()) na++;
            @(negedge clk);
        end
        chk("R11", "no refresh in power-down", na, 0);
    endtask

    task automatic t_normal_fast();
        int n = 0, m = 0;
        send(0, 1'b1, 1'b1, 0, 0);
        while (!is_aref() && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "first refresh at 20", n, 22);
        chk("R9", "refresh targets", sd_cs_n, 2'b00);
        do begin
            @(negedge clk);
            m++;
        end while (!is_aref() && m < 200);
        chk("R9", "refresh period", m, 21);
    endtask

    task automatic t_deferred();
        int g = 0;
        send(3, 1'b1, 1'b1, 15, 0);
        while (status[5] && g < 500) begin
            @(negedge clk);
            g++;
        end
        chk("R6", "long burst busy", g, 16 * TRC);
        chk("R10", "idle one cycle", is_aref(), 0);
        @(negedge clk);
        chk("R10", "held refresh issued", is_aref(), 1);
        chk("R10", "held refresh busy", status[5], 1);
    endtask

    task automatic t_self_refresh();
        int na = 0;
        send(5, 1'b1, 1'b1, 0, 0);
        chk("R11", "cke low in self-refresh", sd_cke, 0);
        chk("R11", "self-refresh pattern", is_aref(), 1);
        @(negedge clk);
        chk("R7", "self-refresh busy one cycle", status[5], 0);
        for (int i = 0; i < 80; i++) begin
            if (is_aref()) na++;
            @(negedge clk);
        end
        chk("R11", "no refresh in self-refresh", na, 0);
        send(0, 1'b1, 1'b1, 0, 0);
        chk("R11", "normal raises cke", sd_cke, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clock_start();
        t_no_target();
        t_precharge();
        t_refresh_burst();
        t_ignored_write();
        t_load_mode();
        t_normal_default();
        t_power_down();
        t_normal_fast();
        t_deferred();
        t_self_refresh();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule